// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block decides where a 32-bit processor with 4-byte instructions fetches next. Each cycle it receives the address of the current instruction, the instruction word and the two source register values already read from the register file. One clock edge later it presents the next fetch address. It also presents the request to write the return address into the link register.

The unit covers straight-line advance, jumps within the current 256 MB region, jumps through a register, branches on equality or inequality of two registers, branches on the sign of one register, and jump-and-link. Taken branch targets are relative to the address after the current instruction, with the 16-bit offset counted in words. Region jumps keep the top four bits of that incremented address and take the remaining bits from the 26-bit target field, shifted left by two.

Top module: `npc_unit`

## Requirements
- R1: While the synchronous active-high reset is asserted at a rising edge, the next edge leaves next_pc_o at RESET_PC (default 0), link_we_o at 0 and link_val_o at 0.
- R2: All outputs are registered. The values presented after a rising edge depend only on the inputs sampled at that edge. For any opcode (bits 31:26) not described below, next_pc_o is pc_i + 4.
- R3: Opcode 2 gives next_pc_o = {pc4[31:28], instr_i[25:0], 2'b00}, where pc4 = pc_i + 4.
- R4: Opcode 0 with function field (bits 5:0) equal to 8 gives next_pc_o = rs_val_i. Opcode 0 with any other function value gives pc_i + 4.
- R5: Opcode 4 is taken when rs_val_i equals rt_val_i, and opcode 5 is taken when they differ. A taken branch gives pc4 + (sign-extended instr_i[15:0] << 2). A branch that is not taken gives pc4.
- R6: Opcode 1 uses the rt field (bits 20:16) as a sub-code. A value of 0 branches when rs_val_i is negative. A value of 1 branches when rs_val_i is zero or positive. Any other value gives pc4.
- R7: Opcode 6 branches when rs_val_i is at most zero, and opcode 7 branches when rs_val_i is greater than zero. Both comparisons are signed.
- R8: Opcode 3 jumps to the same target as opcode 2. It also sets link_we_o = 1 and link_val_o = pc_i + 8, with link_idx_o = 31.
- R9: link_we_o is 1 only after opcode 3 is sampled, and link_val_o is 0 whenever link_we_o is 0. link_idx_o is always 31.
- R10: A region jump (opcode 2 or 3) never changes bits 31:28 of pc4. This holds when pc_i + 4 wraps past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of register selected by bits 25:21 |
| rt_val_i | input | 32 | Value of register selected by bits 20:16 |
| next_pc_o | output | 32 | Registered next fetch address |
| link_we_o | output | 1 | Registered link register write enable |
| link_idx_o | output | 5 | Link register index, fixed at 31 |
| link_val_o | output | 32 | Registered return address |

## Verification
Every one of the 64 opcodes is swept against a grid of register values. The grid holds the most negative value, -1, 0, 1, the most positive value and two mixed words. This grid separates signed from unsigned handling and separates the strict sign tests from the non-strict ones (less-than versus less-or-equal), which the zero and -1 cases tell apart. The function field of opcode 0 and the rt sub-code of opcode 1 are swept in full, so that only the code points that are defined act. The current address is varied across all sixteen regions and includes the top word of the address space, which exposes whether the region bits are taken before or after the increment and whether negative branch offsets wrap correctly.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int OP_W     = 6;
  localparam int FUNCT_W  = 6;
  localparam int RIDX_W   = 5;

  localparam logic [OP_W-1:0]    OP_SPECIAL = 6'h00;
  localparam logic [OP_W-1:0]    OP_SIGNZ   = 6'h01;
  localparam logic [OP_W-1:0]    OP_JMP     = 6'h02;
  localparam logic [OP_W-1:0]    OP_JLINK   = 6'h03;
  localparam logic [OP_W-1:0]    OP_BEQ     = 6'h04;
  localparam logic [OP_W-1:0]    OP_BNE     = 6'h05;
  localparam logic [OP_W-1:0]    OP_BLEZ    = 6'h06;
  localparam logic [OP_W-1:0]    OP_BGTZ    = 6'h07;
  localparam logic [FUNCT_W-1:0] FN_JREG    = 6'h08;

  typedef enum logic [3:0] {
    K_SEQ, K_JMP, K_JLINK, K_JREG,
    K_EQ, K_NE, K_LTZ, K_GEZ, K_LEZ, K_GTZ
  } flow_kind_e;
endpackage

// File: rtl/npc_classify.sv
module npc_classify
  import npc_pkg::*;
(
  input  logic [OP_W-1:0]    op_i,
  input  logic [FUNCT_W-1:0] funct_i,
  input  logic [RIDX_W-1:0]  sub_i,
  output flow_kind_e         kind_o
);
  always_comb begin
    kind_o = K_SEQ;
    unique case (op_i)
      OP_SPECIAL: if (funct_i == FN_JREG) kind_o = K_JREG;
      OP_SIGNZ: begin
        if (sub_i == RIDX_W'(0))      kind_o = K_LTZ;
        else if (sub_i == RIDX_W'(1)) kind_o = K_GEZ;
      end
      OP_JMP:   kind_o = K_JMP;
      OP_JLINK: kind_o = K_JLINK;
      OP_BEQ:   kind_o = K_EQ;
      OP_BNE:   kind_o = K_NE;
      OP_BLEZ:  kind_o = K_LEZ;
      OP_BGTZ:  kind_o = K_GTZ;
      default:  kind_o = K_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  flow_kind_e      kind_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            taken_o
);
  logic neg, zero, same;
  assign neg  = a_i[XLEN-1];
  assign zero = (a_i == '0);
  assign same = (a_i == b_i);

  always_comb begin
    unique case (kind_i)
      K_EQ:    taken_o = same;
      K_NE:    taken_o = !same;
      K_LTZ:   taken_o = neg;
      K_GEZ:   taken_o = !neg;
      K_LEZ:   taken_o = neg || zero;
      K_GTZ:   taken_o = !neg && !zero;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int XLEN        = 32,
  parameter int INSTR_BYTES = 4,
  parameter int IMM_W       = 16,
  parameter int TGT_W       = 26
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [TGT_W-1:0] tgt_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  link_o,
  output logic [XLEN-1:0]  region_o,
  output logic [XLEN-1:0]  rel_o
);
  localparam int ALIGN    = $clog2(INSTR_BYTES);
  localparam int REGION_W = XLEN - TGT_W - ALIGN;
  localparam int SEXT_W   = XLEN - IMM_W - ALIGN;

  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  offset;

  assign imm    = tgt_i[IMM_W-1:0];
  assign seq_o  = pc_i + XLEN'(INSTR_BYTES);
  assign link_o = pc_i + XLEN'(2 * INSTR_BYTES);
  assign offset = {{SEXT_W{imm[IMM_W-1]}}, imm, {ALIGN{1'b0}}};
  assign rel_o  = seq_o + offset;
  assign region_o = {seq_o[XLEN-1 -: REGION_W], tgt_i, {ALIGN{1'b0}}};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              INSTR_BYTES = 4,
  parameter int              IMM_W       = 16,
  parameter int              TGT_W       = 26,
  parameter int              LINK_REG    = 31,
  parameter logic [XLEN-1:0] RESET_PC    = '0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   instr_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_val_o
);
  localparam int OP_LSB  = XLEN - OP_W;
  localparam int SUB_LSB = TGT_W - 2 * RIDX_W;

  flow_kind_e      kind;
  logic            taken;
  logic [XLEN-1:0] seq_pc, link_pc, region_pc, rel_pc;
  logic [XLEN-1:0] npc_d;

  npc_classify u_cls (
    .op_i    (instr_i[XLEN-1 -: OP_W]),
    .funct_i (instr_i[FUNCT_W-1:0]),
    .sub_i   (instr_i[SUB_LSB +: RIDX_W]),
    .kind_o  (kind)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind_i  (kind),
    .a_i     (rs_val_i),
    .b_i     (rt_val_i),
    .taken_o (taken)
  );

  npc_targets #(
    .XLEN(XLEN), .INSTR_BYTES(INSTR_BYTES), .IMM_W(IMM_W), .TGT_W(TGT_W)
  ) u_tgt (
    .pc_i     (pc_i),
    .tgt_i    (instr_i[TGT_W-1:0]),
    .seq_o    (seq_pc),
    .link_o   (link_pc),
    .region_o (region_pc),
    .rel_o    (rel_pc)
  );

  always_comb begin
    unique case (kind)
      K_JMP, K_JLINK: npc_d = region_pc;
      K_JREG:         npc_d = rs_val_i;
      K_SEQ:          npc_d = seq_pc;
      default:        npc_d = taken ? rel_pc : seq_pc;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      next_pc_o  <= RESET_PC;
      link_we_o  <= 1'b0;
      link_val_o <= '0;
    end else begin
      next_pc_o  <= npc_d;
      link_we_o  <= (kind == K_JLINK);
      link_val_o <= (kind == K_JLINK) ? link_pc : '0;
    end
  end

  assign link_idx_o = RIDX_W'(LINK_REG);
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] instr_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] rt_val_i,
  input logic [XLEN-1:0] next_pc_o,
  input logic            link_we_o,
  input logic [XLEN-1:0] link_val_o
);
  logic       run_seen;
  logic [5:0] op;
  assign op = instr_i[XLEN-1 -: 6];

  always_ff @(posedge clk_i) begin
    if (rst_i) run_seen <= 1'b0;
    else       run_seen <= 1'b1;
  end

  p_link_only_jal_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_seen && link_we_o) |-> ($past(op) == 6'h03));

  p_link_value_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_seen && link_we_o) |-> (link_val_o == $past(pc_i) + XLEN'(8)));

  p_seq_advance_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_seen && $past(op) > 6'h07) |-> (next_pc_o == $past(pc_i) + XLEN'(4)));

  p_reg_jump_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_seen && $past(op) == 6'h00 && $past(instr_i[5:0]) == 6'h08)
      |-> (next_pc_o == $past(rs_val_i)));

  p_bne_equal_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_seen && $past(op) == 6'h05 && $past(rs_val_i) == $past(rt_val_i))
      |-> (next_pc_o == $past(pc_i) + XLEN'(4)));

  p_region_kept_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_seen && ($past(op) == 6'h02 || $past(op) == 6'h03))
      |-> (next_pc_o[XLEN-1 -: 4] == $past(pc_i + XLEN'(4)) >> (XLEN - 4)));
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .pc_i       (pc_i),
  .instr_i    (instr_i),
  .rs_val_i   (rs_val_i),
  .rt_val_i   (rt_val_i),
  .next_pc_o  (next_pc_o),
  .link_we_o  (link_we_o),
  .link_val_o (link_val_o)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc = '0, instr = '0, rsv = '0, rtv = '0;
  logic [31:0] next_pc, link_val;
  logic        link_we;
  logic [4:0]  link_idx;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  npc_unit u0 (
    .clk_i(clk), .rst_i(rst), .pc_i(pc), .instr_i(instr),
    .rs_val_i(rsv), .rt_val_i(rtv), .next_pc_o(next_pc),
    .link_we_o(link_we), .link_idx_o(link_idx), .link_val_o(link_val)
  );

  logic [31:0] vals [7] = '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 32'h1,
                            32'h7FFF_FFFF, 32'h1234_5678, 32'hFEDC_BA98};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (pc %h instr %h)", tag, act, exp, pc, instr);
    end
  endtask

  function automatic string tag_of(input logic [31:0] ins);
    case (ins[31:26])
      6'd0: return (ins[5:0] == 6'd8) ? "R4" : "R2";
      6'd1: return "R6";
      6'd2: return "R3";
      6'd3: return "R8";
      6'd4, 6'd5: return "R5";
      6'd6, 6'd7: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic step(input logic [31:0] p, input logic [31:0] ins,
                      input logic [31:0] a, input logic [31:0] b);
    logic [31:0] p4, bt, jt, exp_pc, exp_lv;
    logic        exp_we;
    pc = p; instr = ins; rsv = a; rtv = b;
    p4 = p + 32'd4;
    bt = p4 + {{14{ins[15]}}, ins[15:0], 2'b00};
    jt = {p4[31:28], ins[25:0], 2'b00};
    exp_pc = p4; exp_we = 1'b0; exp_lv = 32'd0;
    case (ins[31:26])
      6'd0: if (ins[5:0] == 6'd8) exp_pc = a;
      6'd1: begin
        if (ins[20:16] == 5'd0 && $signed(a) < 0)  exp_pc = bt;
        if (ins[20:16] == 5'd1 && $signed(a) >= 0) exp_pc = bt;
      end
      6'd2: exp_pc = jt;
      6'd3: begin exp_pc = jt; exp_we = 1'b1; exp_lv = p + 32'd8; end
      6'd4: if (a == b) exp_pc = bt;
      6'd5: if (a != b) exp_pc = bt;
      6'd6: if ($signed(a) <= 0) exp_pc = bt;
      6'd7: if ($signed(a) > 0)  exp_pc = bt;
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    chk(tag_of(ins), next_pc, exp_pc);
    chk("R9 link_we", {31'd0, link_we}, {31'd0, exp_we});
    chk("R9 link_val", link_val, exp_lv);
    chk("R9 link_idx", {27'd0, link_idx}, 32'd31);
    if (ins[31:27] == 5'b00001)
      chk("R10 region", {28'd0, next_pc[31:28]}, {28'd0, p4[31:28]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pc", next_pc, 32'd0);
    chk("R1 we", {31'd0, link_we}, 32'd0);
    chk("R1 val", link_val, 32'd0);
    rst = 1'b0;

    for (int op = 0; op < 64; op++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++) begin
          logic [15:0] imm;
          logic [4:0]  sub;
          imm = 16'(i * 16'h2345 + j * 16'h0F01);
          if (op == 0 && ((i + j) % 2 == 0)) imm[5:0] = 6'h08;
          sub = (op == 1) ? 5'(j % 2) : 5'd5;
          step(32'(op) * 32'h0400_0000 + 32'(i) * 32'h40 + 32'(j) * 4,
               {6'(op), 5'd3, sub, imm}, vals[i], vals[j]);
        end

    for (int f = 0; f < 64; f++)
      step(32'h0040_0100, {6'd0, 5'd2, 5'd4, 10'd0, 6'(f)}, 32'hCAFE_0000, 32'd0);

    for (int s = 0; s < 32; s++) begin
      step(32'h1000_0000, {6'd1, 5'd1, 5'(s), 16'h0010}, 32'hFFFF_FFF0, 32'd0);
      step(32'h1000_0000, {6'd1, 5'd1, 5'(s), 16'hFFF0}, 32'h0000_0010, 32'd0);
    end

    step(32'hFFFF_FFFC, {6'd2, 26'h3FF_FFFF}, 32'd0, 32'd0);
    step(32'hFFFF_FFFC, {6'd3, 26'h000_0001}, 32'd0, 32'd0);
    step(32'hEFFF_FFFC, {6'd2, 26'h000_0000}, 32'd0, 32'd0);
    step(32'h0000_0000, {6'd4, 5'd1, 5'd2, 16'hFFFF}, 32'd9, 32'd9);
    step(32'h0000_0004, {6'd4, 5'd1, 5'd2, 16'h8000}, 32'd9, 32'd9);
    step(32'h0000_0000, {6'd7, 5'd1, 5'd0, 16'h7FFF}, 32'd1, 32'd0);

    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 pc mid", next_pc, 32'd0);
    chk("R1 we mid", {31'd0, link_we}, 32'd0);
    rst = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule